// File: doc/BRIEF.md
# Host Bus Command Port

An 8-bit host bus slave that lets a processor reach a wide internal register space through a small window of four host locations. A strap input picks between two strobe conventions. With separate read and write strobes, a low on the write strobe writes. With a single data strobe plus a read/write level, the level tells a read from a write. The address may come over a multiplexed bus, where it is captured while the address-latch input is high and held once that input falls. It may also come straight in, with the latch input tied high.

The host loads a 16-bit internal address through two byte locations and stages write data in a data location. It then writes a command byte to start an internal access. Accesses that must line up with the internal frame engine set a busy flag and travel on a request channel marked as synchronised. They finish when the internal side accepts them, or when the host cancels them with a terminate command. Other writes travel unsynchronised with busy left at 0. Other reads need no command at all: the data location reflects the addressed register directly. A soft-reset bit in the command byte holds the configuration and routing logic in reset for as long as it is set.

The request channel follows valid/ready. Once `req_valid` rises, address, direction, sync flag and write data stay fixed until `req_ready` is seen high on a clock edge. The one exception is a terminate, which may withdraw a synchronised request. The internal side applies back-pressure by holding `req_ready` low for as long as it needs.

Top module: `hb_cmd_port`

## Requirements
- R1: In separate-strobe mode (`mode_moto`=0), a write with `cs_n` and `wr_n` low is committed once, on the synchronised trailing edge of the strobe. Host offsets 1 and 2 hold the low and high bytes of the internal address, offset 3 the staged write data, and offset 0 the command byte. Offsets 1 and 2 read back what was written.
- R2: In single-strobe mode (`mode_moto`=1), `rd_n` is the data strobe and `wr_n` is the direction level (1 = read, 0 = write). Writes and reads behave as in R1.
- R3: While `ale` is high the host address is used directly. After `ale` falls, the address seen on the last clock with `ale` high is used until `ale` rises again.
- R4: `data_oe` is 1 only while `cs_n` is low and `rd_n` is low, and, in single-strobe mode, `wr_n` is also high. It is 0 during every write.
- R5: Internal address bits [15:12] equal to 1 (routing) or 2 (parallel access) make a write synchronised. A command with bit 2 set raises `req_valid` with `req_we`=1 and `req_sync`=1, carrying the internal address and staged data. Busy (command bit 0 on read) is 1 until the request is accepted.
- R6: A bit-2 command for any other region raises `req_valid` with `req_sync`=0, and busy reads 0.
- R7: A command with bit 1 set starts a synchronised read only for region 2. Busy stays 1 until acceptance, and `req_rdata` at the accepting edge is then returned at offset 3. For any other region, bit 1 has no effect and no request is made.
- R8: When the internal address is not in region 2, offset 3 reads return `look_data` for `look_addr` (the current internal address) at once.
- R9: Command bit 3 clears busy and withdraws a pending synchronised request. When bit 3 is set together with bit 1 or 2, no new request starts.
- R10: Command bits 1 to 3 always read back 0, and bits 6:1 read as 0.
- R11: Command bit 7 reads back as written. `cfg_rst` is 1 while `rst` is 1 or bit 7 is 1.
- R12: While `req_valid` is 1 and `req_ready` is 0, with no terminate, the request fields do not change on the next cycle.
- R13: If a terminate is committed on the same edge that the pending synchronised read is accepted, the transfer counts: the read data is captured and busy ends 0.
- R14: A start command written while a request is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset |
| mode_moto | input | 1 | 0: separate read/write strobes; 1: data strobe plus direction level |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, or data strobe in single-strobe mode |
| wr_n | input | 1 | Write strobe, or direction level (1 read) in single-strobe mode |
| ale | input | 1 | Address latch; tie high for non-multiplexed address |
| addr | input | 10 | Host address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| data_oe | output | 1 | Host data bus drive enable |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal request accepted |
| req_we | output | 1 | Request is a write |
| req_sync | output | 1 | Request needs frame synchronisation |
| req_addr | output | 16 | Request internal address |
| req_wdata | output | 8 | Request write data |
| req_rdata | input | 8 | Read data, valid on the accepting edge |
| look_addr | output | 16 | Current internal address for direct reads |
| look_data | input | 8 | Direct read data for `look_addr` |
| cfg_rst | output | 1 | Reset to configuration and routing logic |

## Verification
Two events can land on the same clock edge: a terminate committed by the host and the acceptance of the pending synchronised read. The bench times the release of the command strobe against the two synchroniser stages, so that `req_ready` is high on exactly the edge where the terminate commits. It then requires that the captured read data appears at offset 3, with busy and `req_valid` both low. A second overlap, a start command written while a request is outstanding, is judged by the request fields staying unchanged.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int OFF_CMD = 0;
  localparam int OFF_ALO = 1;
  localparam int OFF_AHI = 2;
  localparam int OFF_DAT = 3;

  localparam int BIT_BUSY = 0;
  localparam int BIT_RD   = 1;
  localparam int BIT_WR   = 2;
  localparam int BIT_TERM = 3;
  localparam int BIT_SRST = 7;

  localparam logic [3:0] RGN_ROUTE = 4'h1;
  localparam logic [3:0] RGN_PAR   = 4'h2;

  function automatic logic sync_on_write(input logic [3:0] rgn);
    return (rgn == RGN_ROUTE) || (rgn == RGN_PAR);
  endfunction

  function automatic logic sync_on_read(input logic [3:0] rgn);
    return rgn == RGN_PAR;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) st <= RST_VAL;
      else     st <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) st <= {STAGES{RST_VAL}};
      else     st <= {st[STAGES-2:0], d};
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hb_bus_front.sv
module hb_bus_front #(
  parameter int HAW = 10,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_moto,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic           ale,
  input  logic [HAW-1:0] addr,
  input  logic [DW-1:0]  din,
  output logic [HAW-1:0] eff_addr,
  output logic           rd_drive,
  output logic           wr_pulse,
  output logic [HAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data
);
  logic [HAW-1:0] addr_hold;
  logic [2:0]     pins_s;
  logic           act_raw, act_s, act_d;

  always_ff @(posedge clk) begin
    if (rst)      addr_hold <= '0;
    else if (ale) addr_hold <= addr;
  end

  assign eff_addr = ale ? addr : addr_hold;

  assign rd_drive = !cs_n && !rd_n && (mode_moto ? wr_n : 1'b1);

  assign act_raw = mode_moto ? (!cs_n && !rd_n && !wr_n) : (!cs_n && !wr_n);

  hb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, rd_n, wr_n}), .q(pins_s)
  );

  assign act_s = mode_moto ? (!pins_s[2] && !pins_s[1] && !pins_s[0])
                           : (!pins_s[2] && !pins_s[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_d <= act_s;
      if (act_raw) begin
        wr_addr <= eff_addr;
        wr_data <= din;
      end
    end
  end

  assign wr_pulse = act_d && !act_s;

  // R1
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/hb_cmd_engine.sv
module hb_cmd_engine
  import hb_pkg::*;
#(
  parameter int HAW = 10,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HAW-1:0]  eff_addr,
  input  logic            wr_pulse,
  input  logic [HAW-1:0]  wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_we,
  output logic            req_sync,
  output logic [2*DW-1:0] req_addr,
  output logic [DW-1:0]   req_wdata,
  input  logic [DW-1:0]   req_rdata,
  output logic [2*DW-1:0] look_addr,
  input  logic [DW-1:0]   look_data,
  output logic            srst,
  output logic [DW-1:0]   rd_data
);
  localparam int IAW = 2 * DW;

  logic [IAW-1:0] areg;
  logic [DW-1:0]  wreg, rbuf;
  logic           busy_q, v_q, we_q, sy_q;
  logic [IAW-1:0] a_q;
  logic [DW-1:0]  d_q;
  logic [3:0]     rgn;
  logic           hit_cmd, term_cmd, start_wr, start_rd;

  assign rgn      = areg[IAW-1 -: 4];
  assign hit_cmd  = wr_pulse && (wr_addr == HAW'(OFF_CMD));
  assign term_cmd = hit_cmd && wr_data[BIT_TERM];
  assign start_wr = hit_cmd && !term_cmd && !v_q && wr_data[BIT_WR];
  assign start_rd = hit_cmd && !term_cmd && !v_q && !wr_data[BIT_WR]
                    && wr_data[BIT_RD] && sync_on_read(rgn);

  always_ff @(posedge clk) begin
    if (rst) begin
      areg <= '0; wreg <= '0; rbuf <= '0;
      busy_q <= 1'b0; v_q <= 1'b0; we_q <= 1'b0; sy_q <= 1'b0;
      a_q <= '0; d_q <= '0; srst <= 1'b0;
    end else begin
      if (v_q && req_ready) begin
        v_q    <= 1'b0;
        busy_q <= 1'b0;
        if (sy_q && !we_q) rbuf <= req_rdata;
      end
      if (wr_pulse) begin
        if (wr_addr == HAW'(OFF_ALO)) areg[DW-1:0]   <= wr_data;
        if (wr_addr == HAW'(OFF_AHI)) areg[IAW-1:DW] <= wr_data;
        if (wr_addr == HAW'(OFF_DAT)) wreg           <= wr_data;
        if (hit_cmd) srst <= wr_data[BIT_SRST];
      end
      if (term_cmd) begin
        busy_q <= 1'b0;
        if (sy_q) v_q <= 1'b0;
      end
      if (start_wr) begin
        v_q <= 1'b1; we_q <= 1'b1; sy_q <= sync_on_write(rgn);
        busy_q <= sync_on_write(rgn);
        a_q <= areg; d_q <= wreg;
      end else if (start_rd) begin
        v_q <= 1'b1; we_q <= 1'b0; sy_q <= 1'b1; busy_q <= 1'b1;
        a_q <= areg; d_q <= '0;
      end
    end
  end

  assign req_valid = v_q;
  assign req_we    = we_q;
  assign req_sync  = sy_q;
  assign req_addr  = a_q;
  assign req_wdata = d_q;
  assign look_addr = areg;

  always_comb begin
    rd_data = '0;
    if (eff_addr == HAW'(OFF_CMD)) begin
      rd_data[BIT_SRST] = srst;
      rd_data[BIT_BUSY] = busy_q;
    end else if (eff_addr == HAW'(OFF_ALO)) rd_data = areg[DW-1:0];
    else if (eff_addr == HAW'(OFF_AHI))   rd_data = areg[IAW-1:DW];
    else if (eff_addr == HAW'(OFF_DAT))   rd_data = sync_on_read(rgn) ? rbuf : look_data;
  end

  // R5
  busy_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (req_valid && req_sync));
  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !term_cmd) |=>
      (req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_sync) && $stable(req_wdata)));
  // R9
  term_clear_chk: assert property (@(posedge clk) disable iff (rst)
    term_cmd |=> !busy_q);
endmodule

// File: rtl/hb_cmd_port.sv
module hb_cmd_port #(
  parameter int HAW = 10,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_moto,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            ale,
  input  logic [HAW-1:0]  addr,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   dout,
  output logic            data_oe,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_we,
  output logic            req_sync,
  output logic [2*DW-1:0] req_addr,
  output logic [DW-1:0]   req_wdata,
  input  logic [DW-1:0]   req_rdata,
  output logic [2*DW-1:0] look_addr,
  input  logic [DW-1:0]   look_data,
  output logic            cfg_rst
);
  logic [HAW-1:0] eff_addr, wr_addr;
  logic [DW-1:0]  wr_data;
  logic           wr_pulse, srst;

  hb_bus_front #(.HAW(HAW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .mode_moto(mode_moto), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ale(ale), .addr(addr), .din(din), .eff_addr(eff_addr),
    .rd_drive(data_oe), .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  hb_cmd_engine #(.HAW(HAW), .DW(DW)) u_eng (
    .clk(clk), .rst(rst), .eff_addr(eff_addr), .wr_pulse(wr_pulse),
    .wr_addr(wr_addr), .wr_data(wr_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_we(req_we), .req_sync(req_sync),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .look_addr(look_addr), .look_data(look_data), .srst(srst), .rd_data(dout)
  );

  assign cfg_rst = rst || srst;

  // R4
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !cs_n);
  // R11
  srst_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    srst |-> cfg_rst);
endmodule

// File: tb/hb_cmd_port_tb.sv
`timescale 1ns/1ps
module hb_cmd_port_tb_top;
  logic clk = 0, rst = 1;
  logic mode_moto = 0, cs_n = 1, rd_n = 1, wr_n = 1, ale = 1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0, req_rdata = '0;
  logic req_ready = 0;
  logic [7:0] dout, req_wdata, look_data;
  logic data_oe, req_valid, req_we, req_sync, cfg_rst;
  logic [15:0] req_addr, look_addr;

  int n_chk = 0, n_fail = 0;
  bit muxed = 0, in_wr = 0, done = 0, m_srst = 0;

  always #2 clk = ~clk;

  assign look_data = look_addr[7:0] ^ 8'h3C;

  hb_cmd_port dut_i (
    .clk(clk), .rst(rst), .mode_moto(mode_moto), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ale(ale), .addr(addr), .din(din), .dout(dout),
    .data_oe(data_oe), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_sync(req_sync), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .look_addr(look_addr),
    .look_data(look_data), .cfg_rst(cfg_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference comparison of pin-level behaviour (R4, R11)
  always @(negedge clk) begin
    if (!done) begin
      check("R4 oe", data_oe, !cs_n && !rd_n && (mode_moto ? wr_n : 1'b1));
      if (!in_wr) check("R11 cfg_rst", cfg_rst, rst || m_srst);
    end
  end

  task automatic put_addr(input logic [9:0] a);
    if (muxed) begin
      ale = 1; addr = a;
      repeat (2) @(posedge clk);
      @(negedge clk); ale = 0; addr = 10'h2AA;
    end else begin
      ale = 1; addr = a;
    end
  endtask

  task automatic host_wr(input logic [9:0] a, input logic [7:0] d, input bit ready_on_commit);
    in_wr = 1;
    @(negedge clk); put_addr(a);
    @(negedge clk); din = d; cs_n = 0;
    if (mode_moto) begin wr_n = 0; rd_n = 0; end else wr_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); cs_n = 1; rd_n = 1; wr_n = 1; din = 8'hEE;
    if (ready_on_commit) begin
      repeat (2) @(posedge clk);
      @(negedge clk); req_ready = 1;
      @(posedge clk);
      @(negedge clk); req_ready = 0;
      repeat (2) @(posedge clk);
    end else repeat (5) @(posedge clk);
    @(negedge clk);
    in_wr = 0;
  endtask

  task automatic host_rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); put_addr(a);
    @(negedge clk); cs_n = 0; rd_n = 0; wr_n = 1;
    @(posedge clk);
    @(negedge clk); d = dout;
    cs_n = 1; rd_n = 1;
  endtask

  task automatic ack_one();
    @(negedge clk); req_ready = 1;
    @(posedge clk);
    @(negedge clk); req_ready = 0;
  endtask

  task automatic exp_req(input string req, input logic v, input logic we, input logic sy,
                         input logic [15:0] a, input logic [7:0] d);
    check({req, " valid"}, req_valid, v);
    if (v) begin
      check({req, " we"}, req_we, we);
      check({req, " sync"}, req_sync, sy);
      check({req, " addr"}, req_addr, a);
      if (we) check({req, " wdata"}, req_wdata, d);
    end
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R11 reset cfg_rst", cfg_rst, 1);
    check("R5 reset req_valid", req_valid, 0);
    rst = 0;
    @(negedge clk);

    // R1: separate strobes, direct address
    host_rd(10'd0, r); check("R10 reset cmd", r, 8'h00);
    host_wr(10'd1, 8'h34, 0);
    host_wr(10'd2, 8'h12, 0);
    host_rd(10'd1, r); check("R1 alo", r, 8'h34);
    host_rd(10'd2, r); check("R1 ahi", r, 8'h12);
    host_wr(10'd2, 8'h10, 0);   // routing region 0x1034
    host_wr(10'd3, 8'h77, 0);
    host_wr(10'd0, 8'h04, 0);
    exp_req("R5 route wr", 1, 1, 1, 16'h1034, 8'h77);
    host_rd(10'd0, r); check("R5 busy set", r, 8'h01);
    repeat (6) @(posedge clk); @(negedge clk);
    exp_req("R12 hold", 1, 1, 1, 16'h1034, 8'h77);
    ack_one();
    check("R5 ack clears", req_valid, 0);
    host_rd(10'd0, r); check("R10 busy clear", r, 8'h00);

    // R6: unsynchronised write
    host_wr(10'd2, 8'h05, 0);
    host_wr(10'd3, 8'h81, 0);
    host_wr(10'd0, 8'h04, 0);
    exp_req("R6 cfg wr", 1, 1, 0, 16'h0534, 8'h81);
    host_rd(10'd0, r); check("R6 busy zero", r, 8'h00);
    ack_one();

    // R8 direct read, R7 read bit ignored for non-parallel region
    host_wr(10'd1, 8'h55, 0);
    host_rd(10'd3, r); check("R8 direct read", r, 8'h55 ^ 8'h3C);
    host_wr(10'd0, 8'h02, 0);
    check("R7 read ignored", req_valid, 0);
    host_rd(10'd0, r); check("R7 busy stays 0", r, 8'h00);

    // R2 + R3: single strobe mode on a multiplexed bus
    mode_moto = 1; muxed = 1;
    host_wr(10'd2, 8'h20, 0);
    host_wr(10'd1, 8'h10, 0);
    host_rd(10'd1, r); check("R3 latched addr read", r, 8'h10);
    host_rd(10'd2, r); check("R2 ahi", r, 8'h20);
    host_wr(10'd0, 8'h02, 0);
    exp_req("R7 par rd", 1, 0, 1, 16'h2010, 8'h00);
    host_rd(10'd0, r); check("R7 busy", r, 8'h01);
    req_rdata = 8'hC3;
    ack_one();
    req_rdata = 8'h00;
    host_rd(10'd3, r); check("R7 captured data", r, 8'hC3);

    // R14: start ignored while pending, R9 terminate
    host_wr(10'd3, 8'h6B, 0);
    host_wr(10'd0, 8'h04, 0);
    host_wr(10'd0, 8'h02, 0);
    exp_req("R14 ignored", 1, 1, 1, 16'h2010, 8'h6B);
    host_wr(10'd0, 8'h08, 0);
    check("R9 withdrawn", req_valid, 0);
    host_rd(10'd0, r); check("R9 busy clear", r, 8'h00);
    host_wr(10'd0, 8'h0C, 0);
    check("R9 terminate wins", req_valid, 0);
    host_rd(10'd0, r); check("R10 cmd bits read 0", r, 8'h00);

    // R13: terminate on the accepting edge
    host_wr(10'd0, 8'h02, 0);
    exp_req("R13 pending rd", 1, 0, 1, 16'h2010, 8'h00);
    req_rdata = 8'h9E;
    host_wr(10'd0, 8'h08, 1);
    req_rdata = 8'h00;
    check("R13 valid low", req_valid, 0);
    host_rd(10'd3, r); check("R13 data captured", r, 8'h9E);
    host_rd(10'd0, r); check("R13 busy low", r, 8'h00);

    // R11 soft reset
    host_wr(10'd0, 8'h80, 0); m_srst = 1;
    host_rd(10'd0, r); check("R11 bit7 reads", r, 8'h80);
    check("R11 cfg_rst on", cfg_rst, 1);
    host_wr(10'd0, 8'h00, 0); m_srst = 0;
    check("R11 cfg_rst off", cfg_rst, 0);

    // R4: no drive during writes or without select
    @(negedge clk); cs_n = 0; rd_n = 0; wr_n = 0;
    @(negedge clk); check("R4 moto write no oe", data_oe, 0);
    cs_n = 1; rd_n = 1; wr_n = 1;
    mode_moto = 0; muxed = 0; ale = 1;
    @(negedge clk); cs_n = 0; wr_n = 0;
    @(negedge clk); check("R4 write strobe no oe", data_oe, 0);
    cs_n = 1; wr_n = 1; rd_n = 0;
    @(negedge clk); check("R4 no select no oe", data_oe, 0);
    rd_n = 1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R1 stray strobes no request", req_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule